// File: doc/BRIEF.md
# Receive Buffer Auto-Clear Controller

This block owns one packet buffer for a single pipe. In the read direction, a packet receiver writes bytes into the buffer, and a DMA engine then drains them through a read port. When a packet ends, the block works out why it ended. The possible reasons are: the buffer filled, a zero-length packet arrived, a short packet arrived, or the transfer count ran out. Once the DMA has read every stored byte, the block either releases the buffer by itself or holds it and raises a flag telling software to clear it.

Two configuration bits settle the outcome after the read completes. One is an auto-clear enable. The other is a ready-mode bit, which controls whether short packets and count-ended packets are held for software. With auto-clear enabled, the buffer is always released by hardware in one cycle, so DMA transfers run without software.

In the write direction, the DMA fills the buffer. The buffer becomes valid either when it fills or when a sampled DMA transfer-end pulse arrives. In that direction the buffer is held until software clears it.

Top module: `rxbuf_autoclr`

## Requirements
- R1: Accepted bytes are stored at consecutive addresses from 0, and `byte_cnt` counts them. Each accepted `dma_rd` returns the next stored byte on `rd_data` one clock later, in write order.
- R2: In the read direction, `pkt_end` (or the write that brings the count to DEPTH) sets `buf_ready` on the next edge and records `end_reason`. The codes are 0 = buffer full, 1 = zero-length, 2 = short, 3 = transfer count ended. The priority order is: count equal to DEPTH gives 0; otherwise a count of 0 gives 1; otherwise `pkt_tc_last` gives 3, and its absence gives 2.
- R3: While `buf_ready` is 1, `pkt_wr` and `pkt_end` are ignored, and `byte_cnt` does not change.
- R4: The read is complete in the cycle where `buf_ready` is 1 and the number of bytes read equals `byte_cnt`. A zero-length packet is therefore complete in the first cycle it is ready.
- R5: If completion leads to a hardware release, then on the next edge `buf_ready` and `byte_cnt` return to 0, and `hw_clr` is 1 for exactly one cycle.
- R6: With `cfg_auto_clr` = 0, the need for a software clear is decided by the end reason and the ready-mode bit:
  - A full buffer never needs one.
  - A zero-length packet always needs one.
  - A short packet or a count-ended packet needs one only when `cfg_rdy_mode` = 1.
  - When a clear is needed, `clr_required` rises on the completion edge, and the buffer stays ready until `sw_clr`. When no clear is needed, the buffer is released as in R5.
- R7: With `cfg_auto_clr` = 1, every completion is released as in R5, and `clr_required` stays 0 for all four end reasons.
- R8: `sw_clr` empties the buffer, sets `buf_ready` and `clr_required` to 0 on the next edge, and overrides a `pkt_wr` in the same cycle.
- R9: In the write direction (`cfg_rd_dir` = 0), `dma_rd` is ignored, no hardware release happens, and `clr_required` stays 0. A ready buffer stays ready until `sw_clr`, even with `cfg_auto_clr` = 1.
- R10: In the write direction, the buffer becomes ready on the edge where a write brings the count to DEPTH. It also becomes ready on the edge where `dma_tend` is high while `cfg_tend_en` = 1 and `cfg_xfer16` = 0.
- R11: `dma_tend` has no effect when `cfg_tend_en` = 0, or when `cfg_xfer16` = 1 (16-byte DMA transfers).
- R12: After reset, `buf_ready`, `byte_cnt`, `clr_required` and `hw_clr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_dir | input | 1 | 1 = receive/read direction, 0 = DMA write direction |
| cfg_auto_clr | input | 1 | Hardware release after every completed read |
| cfg_rdy_mode | input | 1 | Hold short and count-ended packets for software |
| cfg_tend_en | input | 1 | Sample `dma_tend` as a buffer-valid condition |
| cfg_xfer16 | input | 1 | DMA transfer size is 16 bytes (blocks `dma_tend` sampling) |
| pkt_wr | input | 1 | Write one byte into the buffer |
| pkt_data | input | DW | Byte written with `pkt_wr` |
| pkt_end | input | 1 | Packet ends (read direction) |
| pkt_tc_last | input | 1 | Packet was the last one of the transfer count |
| dma_rd | input | 1 | DMA read strobe |
| dma_tend | input | 1 | DMA transfer-end pulse |
| sw_clr | input | 1 | Software buffer clear strobe |
| rd_data | output | DW | Registered read data |
| buf_ready | output | 1 | Buffer holds a finished packet |
| byte_cnt | output | CW | Bytes stored |
| end_reason | output | 2 | Recorded end reason code |
| clr_required | output | 1 | Software must clear the buffer |
| hw_clr | output | 1 | One-cycle pulse after a hardware release |

## Verification
The bench sweeps every end reason, both ready-mode values and both auto-clear values, using packet lengths 0, 1, 5 and the full depth.

- A wrong decision table would show up as a held buffer where a release was due, or the reverse. A design that ignored the auto-clear bit would raise `clr_required` for zero-length packets.
- A design that gave count-ended packets priority over the full condition would report reason 3 for a packet that filled the buffer.
- A design that completed a zero-length packet late, or released the buffer one read early, would show `buf_ready` at the wrong edge and truncated read data.
- In the write direction, the bench checks that the transfer-end pulse is ignored when sampling is disabled or the transfer size is 16 bytes. It also checks that the auto-clear bit does not release a buffer there.

// File: rtl/rxclr_pkg.sv
package rxclr_pkg;
  typedef enum logic [1:0] {
    END_FULL  = 2'd0,
    END_ZLP   = 2'd1,
    END_SHORT = 2'd2,
    END_TCNT  = 2'd3
  } end_t;
endpackage

// File: rtl/rxclr_ram.sv
module rxclr_ram #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxclr_classify.sv
module rxclr_classify
  import rxclr_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] new_cnt,
  input  logic          tc_last,
  input  end_t          held_reason,
  input  logic          rdy_mode,
  output end_t          reason_new,
  output logic          need_clear
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  // Full outranks zero-length, which outranks the count-ended flag.
  always_comb begin
    if (new_cnt == FULL_CNT)  reason_new = END_FULL;
    else if (new_cnt == '0)   reason_new = END_ZLP;
    else if (tc_last)         reason_new = END_TCNT;
    else                      reason_new = END_SHORT;
  end

  always_comb begin
    unique case (held_reason)
      END_FULL:  need_clear = 1'b0;
      END_ZLP:   need_clear = 1'b1;
      default:   need_clear = rdy_mode;
    endcase
  end
endmodule

// File: rtl/rxbuf_autoclr.sv
module rxbuf_autoclr
  import rxclr_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_rd_dir,
  input  logic          cfg_auto_clr,
  input  logic          cfg_rdy_mode,
  input  logic          cfg_tend_en,
  input  logic          cfg_xfer16,
  input  logic          pkt_wr,
  input  logic [DW-1:0] pkt_data,
  input  logic          pkt_end,
  input  logic          pkt_tc_last,
  input  logic          dma_rd,
  input  logic          dma_tend,
  input  logic          sw_clr,
  output logic [DW-1:0] rd_data,
  output logic          buf_ready,
  output logic [CW-1:0] byte_cnt,
  output logic [1:0]    end_reason,
  output logic          clr_required,
  output logic          hw_clr
);
  localparam logic [CW-1:0] LAST_SLOT = CW'(DEPTH - 1);

  logic [CW-1:0] cnt_q, rptr_q, new_cnt;
  logic          ready_q, req_q, hwclr_q;
  end_t          reason_q, reason_new;
  logic          wr_ok, rd_ok, fill, tend_ok, go_ready;
  logic          complete, need_clear, release_now;

  assign wr_ok    = pkt_wr && !ready_q && !sw_clr;
  assign rd_ok    = dma_rd && ready_q && cfg_rd_dir && (rptr_q < cnt_q) && !sw_clr;
  assign new_cnt  = cnt_q + {{(CW-1){1'b0}}, wr_ok};
  assign fill     = wr_ok && (cnt_q == LAST_SLOT);
  assign tend_ok  = dma_tend && cfg_tend_en && !cfg_xfer16;
  assign go_ready = !ready_q && (fill ||
                    (cfg_rd_dir ? pkt_end : tend_ok));

  // Read done: every stored byte has been handed to the DMA.
  assign complete    = ready_q && cfg_rd_dir && !req_q && (rptr_q == cnt_q);
  assign release_now = complete && (cfg_auto_clr || !need_clear);

  rxclr_classify #(.DEPTH(DEPTH), .CW(CW)) i_classify (
    .new_cnt     (new_cnt),
    .tc_last     (pkt_tc_last),
    .held_reason (reason_q),
    .rdy_mode    (cfg_rdy_mode),
    .reason_new  (reason_new),
    .need_clear  (need_clear)
  );

  rxclr_ram #(.DW(DW), .DEPTH(DEPTH), .AW(AW)) i_ram (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (cnt_q[AW-1:0]),
    .wdata (pkt_data),
    .re    (rd_ok),
    .raddr (rptr_q[AW-1:0]),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q    <= '0;
      rptr_q   <= '0;
      ready_q  <= 1'b0;
      req_q    <= 1'b0;
      hwclr_q  <= 1'b0;
      reason_q <= END_FULL;
    end else if (sw_clr) begin
      cnt_q   <= '0;
      rptr_q  <= '0;
      ready_q <= 1'b0;
      req_q   <= 1'b0;
      hwclr_q <= 1'b0;
    end else if (release_now) begin
      cnt_q   <= '0;
      rptr_q  <= '0;
      ready_q <= 1'b0;
      hwclr_q <= 1'b1;
    end else begin
      hwclr_q <= 1'b0;
      if (complete) req_q  <= 1'b1;
      if (wr_ok)    cnt_q  <= new_cnt;
      if (rd_ok)    rptr_q <= rptr_q + 1'b1;
      if (go_ready) begin
        ready_q <= 1'b1;
        if (cfg_rd_dir) reason_q <= reason_new;
      end
    end
  end

  assign buf_ready    = ready_q;
  assign byte_cnt     = cnt_q;
  assign end_reason   = reason_q;
  assign clr_required = req_q;
  assign hw_clr       = hwclr_q;
endmodule

// File: rtl/rxclr_chk.sv
module rxclr_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_rd_dir,
  input logic          sw_clr,
  input logic          buf_ready,
  input logic [CW-1:0] byte_cnt,
  input logic [1:0]    end_reason,
  input logic          clr_required,
  input logic          hw_clr
);
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    byte_cnt <= CW'(DEPTH)); // R1

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    buf_ready && $past(buf_ready) |-> byte_cnt == $past(byte_cnt)); // R3

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (rst)
    clr_required && !sw_clr |=> clr_required && buf_ready); // R6

  AST_FULL_NO_REQ: assert property (@(posedge clk) disable iff (rst)
    clr_required |-> end_reason != 2'd0); // R6

  AST_HWCLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    hw_clr |-> !clr_required && !buf_ready && byte_cnt == '0); // R5

  AST_SWCLR_EMPTY: assert property (@(posedge clk) disable iff (rst)
    sw_clr |=> !buf_ready && !clr_required && byte_cnt == '0); // R8

  AST_WRDIR_NO_HWCLR: assert property (@(posedge clk) disable iff (rst)
    !cfg_rd_dir |=> !hw_clr); // R9
endmodule

bind rxbuf_autoclr rxclr_chk #(.DEPTH(DEPTH), .CW(CW)) i_chk (
  .clk          (clk),
  .rst          (rst),
  .cfg_rd_dir   (cfg_rd_dir),
  .sw_clr       (sw_clr),
  .buf_ready    (buf_ready),
  .byte_cnt     (byte_cnt),
  .end_reason   (end_reason),
  .clr_required (clr_required),
  .hw_clr       (hw_clr)
);

// File: tb/test_rxbuf_autoclr.sv
module test_rxbuf_autoclr;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 8;
  localparam int DEPTH = 8;
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_rd_dir = 1'b1, cfg_auto_clr = 1'b0, cfg_rdy_mode = 1'b0;
  logic cfg_tend_en = 1'b0, cfg_xfer16 = 1'b0;
  logic pkt_wr = 1'b0, pkt_end = 1'b0, pkt_tc_last = 1'b0;
  logic [DW-1:0] pkt_data = '0;
  logic dma_rd = 1'b0, dma_tend = 1'b0, sw_clr = 1'b0;
  logic [DW-1:0] rd_data;
  logic buf_ready, clr_required, hw_clr;
  logic [CW-1:0] byte_cnt;
  logic [1:0] end_reason;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rxbuf_autoclr #(.DW(DW), .DEPTH(DEPTH)) i_rxbuf_autoclr (
    .clk(clk), .rst(rst), .cfg_rd_dir(cfg_rd_dir), .cfg_auto_clr(cfg_auto_clr),
    .cfg_rdy_mode(cfg_rdy_mode), .cfg_tend_en(cfg_tend_en), .cfg_xfer16(cfg_xfer16),
    .pkt_wr(pkt_wr), .pkt_data(pkt_data), .pkt_end(pkt_end), .pkt_tc_last(pkt_tc_last),
    .dma_rd(dma_rd), .dma_tend(dma_tend), .sw_clr(sw_clr), .rd_data(rd_data),
    .buf_ready(buf_ready), .byte_cnt(byte_cnt), .end_reason(end_reason),
    .clr_required(clr_required), .hw_clr(hw_clr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [DW-1:0] pat(input int n, input int i);
    return DW'((n * 37 + i * 11 + 5) & 255);
  endfunction

  task automatic do_swclr();
    sw_clr = 1'b1;
    tick();
    sw_clr = 1'b0;
  endtask

  task automatic run_rx(input int n, input bit tc, input bit au, input bit rm);
    int exp_reason;
    bit need;
    cfg_rd_dir = 1'b1; cfg_auto_clr = au; cfg_rdy_mode = rm;
    if (n == 0) begin
      pkt_end = 1'b1; pkt_tc_last = tc;
      tick();
    end else begin
      for (int i = 0; i < n; i++) begin
        pkt_wr = 1'b1; pkt_data = pat(n, i);
        pkt_end = (i == n - 1); pkt_tc_last = tc;
        tick();
      end
    end
    pkt_wr = 1'b0; pkt_end = 1'b0; pkt_tc_last = 1'b0;
    exp_reason = (n == DEPTH) ? 0 : (n == 0) ? 1 : tc ? 3 : 2;
    need = (exp_reason == 1) || (exp_reason >= 2 && rm);
    chk("R2 ready", int'(buf_ready), 1);
    chk("R2 reason", int'(end_reason), exp_reason);
    chk("R1 count", int'(byte_cnt), n);
    if (n > 0) begin
      pkt_wr = 1'b1; pkt_end = 1'b1; pkt_data = 8'hEE;
      tick();
      pkt_wr = 1'b0; pkt_end = 1'b0;
      chk("R3 write ignored", int'(byte_cnt), n);
      for (int i = 0; i < n; i++) begin
        dma_rd = 1'b1;
        tick();
        chk("R1 read data", int'(rd_data), int'(pat(n, i)));
        if (i < n - 1) chk("R4 not yet done", int'(buf_ready), 1);
      end
      dma_rd = 1'b0;
    end
    tick();
    if (au || !need) begin
      chk(au ? "R7 released" : "R6 released", int'(buf_ready), 0);
      chk("R5 count zero", int'(byte_cnt), 0);
      chk("R5 pulse", int'(hw_clr), 1);
      chk(au ? "R7 no request" : "R6 no request", int'(clr_required), 0);
      tick();
      chk("R5 pulse ends", int'(hw_clr), 0);
    end else begin
      chk("R6 request", int'(clr_required), 1);
      chk("R6 held", int'(buf_ready), 1);
      chk("R4 no pulse", int'(hw_clr), 0);
      tick();
      chk("R6 still held", int'(clr_required) + int'(buf_ready), 2);
      do_swclr();
      chk("R8 ready off", int'(buf_ready), 0);
      chk("R8 request off", int'(clr_required), 0);
      chk("R8 count", int'(byte_cnt), 0);
    end
  endtask

  task automatic wr_bytes(input int k);
    for (int i = 0; i < k; i++) begin
      pkt_wr = 1'b1; pkt_data = pat(99, i);
      tick();
    end
    pkt_wr = 1'b0;
  endtask

  task automatic pulse_tend();
    dma_tend = 1'b1;
    tick();
    dma_tend = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int lens [4] = '{0, 1, 5, DEPTH};
    @(negedge clk);
    repeat (3) tick();
    rst = 1'b0;
    tick();
    chk("R12 ready", int'(buf_ready), 0);
    chk("R12 count", int'(byte_cnt), 0);
    chk("R12 request", int'(clr_required), 0);
    chk("R12 pulse", int'(hw_clr), 0);

    for (int li = 0; li < 4; li++)
      for (int tc = 0; tc < 2; tc++)
        for (int au = 0; au < 2; au++)
          for (int rm = 0; rm < 2; rm++)
            run_rx(lens[li], tc[0], au[0], rm[0]);

    // R8: software clear overrides a same-cycle write
    cfg_rd_dir = 1'b1;
    wr_bytes(2);
    sw_clr = 1'b1; pkt_wr = 1'b1;
    tick();
    sw_clr = 1'b0; pkt_wr = 1'b0;
    chk("R8 write overridden", int'(byte_cnt), 0);
    chk("R8 not ready", int'(buf_ready), 0);

    // Write direction
    cfg_rd_dir = 1'b0; cfg_auto_clr = 1'b1; cfg_tend_en = 1'b1; cfg_xfer16 = 1'b0;
    wr_bytes(3);
    chk("R10 waits for tend", int'(buf_ready), 0);
    pulse_tend();
    chk("R10 tend ready", int'(buf_ready), 1);
    chk("R10 tend count", int'(byte_cnt), 3);
    dma_rd = 1'b1;
    repeat (4) tick();
    dma_rd = 1'b0;
    tick();
    chk("R9 held", int'(buf_ready), 1);
    chk("R9 no pulse", int'(hw_clr), 0);
    chk("R9 no request", int'(clr_required), 0);
    chk("R9 count kept", int'(byte_cnt), 3);
    do_swclr();
    chk("R9 sw clear", int'(buf_ready), 0);

    cfg_xfer16 = 1'b1;
    wr_bytes(2);
    pulse_tend();
    chk("R11 xfer16 blocks tend", int'(buf_ready), 0);
    cfg_xfer16 = 1'b0; cfg_tend_en = 1'b0;
    pulse_tend();
    chk("R11 disabled tend", int'(buf_ready), 0);
    wr_bytes(DEPTH - 3);
    chk("R10 not yet full", int'(buf_ready), 0);
    wr_bytes(1);
    chk("R10 full ready", int'(buf_ready), 1);
    chk("R10 full count", int'(byte_cnt), DEPTH);
    repeat (3) tick();
    chk("R9 full held", int'(buf_ready), 1);
    do_swclr();
    chk("R8 final clear", int'(byte_cnt), 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule